// File: doc/BRIEF.md
# Parallel EEPROM Write/Poll Sequencer

This block sits between an on-chip requester and a byte-wide parallel EEPROM that has asynchronous chip-enable, output-enable and write-enable strobes. A requester hands over one read or one write at a time on a valid/ready handshake. The sequencer then drives the memory strobes with every setup, hold, pulse-width and access time met. Each of these times is a parameter in nanoseconds. It is turned into a whole number of system-clock cycles by rounding up at the configured clock period.

A write does not finish when the strobe ends, because the memory keeps programming on its own for up to about a millisecond. The sequencer therefore reads the written address back, one full read cycle after another. It stops once the most significant data bit of the returned byte equals the bit that was written. If that never happens within a parameterised time limit, the write ends with an error flag. The bidirectional data bus is split into an output byte, an input byte and a drive enable, so that a pad ring can build the tri-state buffer.

Top module: `eep_host_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, mem_ce_n, mem_oe_n and mem_we_n are high, mem_doe is low, req_ready is high and rsp_valid is low.
- R2: Every write strobe keeps mem_we_n low for at least max(ceil(tWPL), ceil(tDS)) cycles (20 at defaults), with mem_ce_n low and mem_oe_n high in every one of those cycles.
- R3: mem_addr, mem_dout and mem_doe=1 are stable for at least max(ceil(tAS), ceil(tOES)) cycles (2 at defaults) before mem_we_n falls, and they stay unchanged while it is low.
- R4: After mem_we_n rises, mem_addr and mem_dout are held with mem_doe high and mem_ce_n low for at least max(ceil(tAH), ceil(tDH), ceil(tOEH)) cycles (10 at defaults).
- R5: A read holds mem_ce_n and mem_oe_n low together, with mem_addr unchanged, for at least max(ceil(tACC), ceil(tOE)) cycles (30 at defaults). The byte on mem_din in the last of those cycles is returned on rsp_rdata with rsp_valid.
- R6: After a write strobe, the block reads the written address over and over. Each read is a complete cycle, with mem_oe_n going high between reads. The write is reported done only when bit 7 of a polled byte equals bit 7 of the written byte, and rsp_rdata then carries that polled byte.
- R7: If no poll has matched by the end of a poll that finishes at or after ceil(POLL_TIMEOUT_NS) cycles from the rise of mem_we_n, the block gives rsp_valid with rsp_error=1 and returns to idle, ready for the next request. Responses that complete normally carry rsp_error=0.
- R8: req_ready is low from the cycle after a request is accepted until rsp_valid. A request presented in that window has no effect on the memory.
- R9: mem_doe is never high and mem_we_n is never low in a cycle where mem_oe_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse when a request completes |
| rsp_rdata | output | DATA_W | Byte read, or last polled byte after a write |
| rsp_error | output | 1 | Write polling timed out |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dout | output | DATA_W | Data driven toward the memory |
| mem_din | input | DATA_W | Data returned by the memory |
| mem_doe | output | 1 | Data bus drive enable |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |

## Verification
The bench models the memory with an access counter: it returns a wrong byte until chip and output enable have been low for the full access time. A sequencer that shortens the read window one cycle therefore returns bad data, and it also fails the pulse-length monitor. The memory model inverts bit 7 while it is busy and can be held busy forever. A design that trusts the first poll, compares the wrong bit, or has no timeout would finish early, report the wrong byte, or hang until the watchdog fires. Bus monitors measure setup, pulse and hold windows to the exact cycle and flag bus contention. A stray request held during a busy write checks that the sequencer neither accepts it nor lets it reach memory.

// File: rtl/eep_pkg.sv
// Shared types and cycle-conversion helpers for the parallel EEPROM sequencer.
// Assumes all timing parameters are given in nanoseconds and the clock period in picoseconds.
package eep_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WSET,
        ST_WSTB,
        ST_WHLD,
        ST_WGAP,
        ST_PACC,
        ST_PREC,
        ST_RACC,
        ST_RREC
    } seq_state_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic doe;
    } bus_ctl_t;

    // Round a nanosecond minimum up to whole clock cycles, never below one.
    function automatic int unsigned ns_to_cycles(longint unsigned ns, longint unsigned period_ps);
        longint unsigned c;
        c = (ns * 64'd1000 + period_ps - 64'd1) / period_ps;
        if (c == 64'd0) c = 64'd1;
        return int'(c);
    endfunction

    // Larger of two counts.
    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Counter width able to hold the value v.
    function automatic int unsigned bits_for(int unsigned v);
        int unsigned w;
        w = $clog2(v + 1);
        return (w < 1) ? 1 : w;
    endfunction

endpackage

// File: rtl/eep_cycle_timer.sv
// Down-counter that times each bus phase.
// A load sets the count to (phase length - 1); done is high while the count is zero,
// so a phase entered with a load lasts exactly the requested number of cycles.
module eep_cycle_timer #(
    parameter int unsigned TW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          done
);
    logic [TW-1:0] cnt_q;

    // Load a new phase length or count the current one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

    AST_TMR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));  // R2
endmodule

// File: rtl/eep_poll_watch.sv
// Write-completion time limit. Counts cycles from the end of a write strobe while
// polling runs, saturating at LIMIT; expired means the limit has been reached.
// Assumes clear and run are never high in the same cycle.
module eep_poll_watch #(
    parameter int unsigned LIMIT = 200000,
    parameter int unsigned MW    = 18
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam logic [MW-1:0] LIM_V = MW'(LIMIT);

    logic [MW-1:0] cnt_q;

    // Restart at a strobe end, then count polling cycles up to the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (run && (cnt_q < LIM_V)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q >= LIM_V);

    AST_TMO_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !expired);  // R7
endmodule

// File: rtl/eep_seq_fsm.sv
// Bus sequencer: accepts one request, walks the write, poll or read phases and
// registers the memory strobes so they change only on clock edges.
// Assumes each *_CYC parameter is at least 1 and fits in TW bits.
module eep_seq_fsm
    import eep_pkg::*;
#(
    parameter int unsigned ADDR_W  = 9,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned TW      = 5,
    parameter int unsigned SET_CYC = 2,
    parameter int unsigned STB_CYC = 20,
    parameter int unsigned HLD_CYC = 10,
    parameter int unsigned GAP_CYC = 10,
    parameter int unsigned ACC_CYC = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_error,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    input  logic [DATA_W-1:0] mem_din,
    output logic              mem_doe,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              tmr_load,
    output logic [TW-1:0]     tmr_val,
    input  logic              tmr_done,
    output logic              tmo_clear,
    output logic              tmo_run,
    input  logic              tmo_hit
);
    localparam int unsigned   MSB   = DATA_W - 1;
    localparam logic [TW-1:0] SET_V = TW'(SET_CYC - 1);
    localparam logic [TW-1:0] STB_V = TW'(STB_CYC - 1);
    localparam logic [TW-1:0] HLD_V = TW'(HLD_CYC - 1);
    localparam logic [TW-1:0] GAP_V = TW'(GAP_CYC - 1);
    localparam logic [TW-1:0] ACC_V = TW'(ACC_CYC - 1);

    seq_state_e        state_q, state_d;
    bus_ctl_t          ctl_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] cap_q;
    logic              match_q;
    logic              rsp_valid_q, rsp_error_q;
    logic [DATA_W-1:0] rsp_rdata_q;

    // Strobe levels that belong to each phase.
    function automatic bus_ctl_t ctl_for(seq_state_e s);
        bus_ctl_t c;
        c = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, doe: 1'b0};
        case (s)
            ST_WSET, ST_WHLD: begin c.ce_n = 1'b0; c.doe = 1'b1; end
            ST_WSTB:          begin c.ce_n = 1'b0; c.doe = 1'b1; c.we_n = 1'b0; end
            ST_PACC, ST_RACC: begin c.ce_n = 1'b0; c.oe_n = 1'b0; end
            default:          ;
        endcase
        return c;
    endfunction

    // Next phase and phase-timer reload.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state_q)
            ST_IDLE: if (req_valid) begin
                tmr_load = 1'b1;
                if (req_write) begin state_d = ST_WSET; tmr_val = SET_V; end
                else           begin state_d = ST_RACC; tmr_val = ACC_V; end
            end
            ST_WSET: if (tmr_done) begin state_d = ST_WSTB; tmr_load = 1'b1; tmr_val = STB_V; end
            ST_WSTB: if (tmr_done) begin state_d = ST_WHLD; tmr_load = 1'b1; tmr_val = HLD_V; end
            ST_WHLD: if (tmr_done) begin state_d = ST_WGAP; tmr_load = 1'b1; tmr_val = GAP_V; end
            ST_WGAP: if (tmr_done) begin state_d = ST_PACC; tmr_load = 1'b1; tmr_val = ACC_V; end
            ST_PACC: if (tmr_done) begin state_d = ST_PREC; tmr_load = 1'b1; tmr_val = GAP_V; end
            ST_PREC: if (tmr_done) begin
                if (match_q || tmo_hit) begin
                    state_d = ST_IDLE;
                end else begin
                    state_d  = ST_PACC;
                    tmr_load = 1'b1;
                    tmr_val  = ACC_V;
                end
            end
            ST_RACC: if (tmr_done) begin state_d = ST_RREC; tmr_load = 1'b1; tmr_val = GAP_V; end
            ST_RREC: if (tmr_done) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Phase register and registered strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ctl_q   <= '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, doe: 1'b0};
        end else begin
            state_q <= state_d;
            ctl_q   <= ctl_for(state_d);
        end
    end

    // Request capture at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (state_q == ST_IDLE && req_valid) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Sample the bus at the last cycle of every read window and note a poll match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q   <= '0;
            match_q <= 1'b0;
        end else if ((state_q == ST_PACC || state_q == ST_RACC) && tmr_done) begin
            cap_q   <= mem_din;
            match_q <= (mem_din[MSB] == wdata_q[MSB]);
        end
    end

    // Completion pulse with the returned byte and the timeout flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_rdata_q <= '0;
            rsp_error_q <= 1'b0;
        end else begin
            rsp_valid_q <= 1'b0;
            if (state_q == ST_RREC && tmr_done) begin
                rsp_valid_q <= 1'b1;
                rsp_rdata_q <= cap_q;
                rsp_error_q <= 1'b0;
            end else if (state_q == ST_PREC && tmr_done && (match_q || tmo_hit)) begin
                rsp_valid_q <= 1'b1;
                rsp_rdata_q <= cap_q;
                rsp_error_q <= !match_q;
            end
        end
    end

    assign tmo_clear = (state_q == ST_WSTB) && tmr_done;
    assign tmo_run   = (state_q == ST_WHLD) || (state_q == ST_WGAP) ||
                       (state_q == ST_PACC) || (state_q == ST_PREC);

    assign req_ready = (state_q == ST_IDLE);
    assign rsp_valid = rsp_valid_q;
    assign rsp_rdata = rsp_rdata_q;
    assign rsp_error = rsp_error_q;
    assign mem_addr  = addr_q;
    assign mem_dout  = wdata_q;
    assign mem_doe   = ctl_q.doe;
    assign mem_ce_n  = ctl_q.ce_n;
    assign mem_oe_n  = ctl_q.oe_n;
    assign mem_we_n  = ctl_q.we_n;

    AST_STROBE_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> ($stable(mem_addr) && $stable(mem_dout) && mem_doe));  // R3
    AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);  // R8
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_doe && mem_we_n));  // R9
    AST_ERR_NEEDS_TMO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_error) |-> $past(tmo_hit));  // R7
    AST_DONE_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_error) |-> $past(!req_ready));  // R8
    AST_POLL_BIT_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_error && $past(state_q == ST_PREC)) |->
        (rsp_rdata[MSB] == wdata_q[MSB]));  // R6
endmodule

// File: rtl/eep_host_seq.sv
// Top of the parallel EEPROM sequencer: converts nanosecond minimums to cycle
// counts and wires the sequencer to its phase timer and its polling time limit.
// Assumes a single requester and a memory that flips bit 7 of the polled byte while busy.
module eep_host_seq
    import eep_pkg::*;
#(
    parameter int unsigned ADDR_W          = 9,
    parameter int unsigned DATA_W          = 8,
    parameter int unsigned CLK_PERIOD_PS   = 5000,
    parameter int unsigned T_AS_NS         = 10,
    parameter int unsigned T_AH_NS         = 50,
    parameter int unsigned T_DS_NS         = 50,
    parameter int unsigned T_DH_NS         = 10,
    parameter int unsigned T_WPL_NS        = 100,
    parameter int unsigned T_WPH_NS        = 50,
    parameter int unsigned T_OES_NS        = 10,
    parameter int unsigned T_OEH_NS        = 10,
    parameter int unsigned T_ACC_NS        = 150,
    parameter int unsigned T_OE_NS         = 70,
    parameter int unsigned POLL_TIMEOUT_NS = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_error,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    input  logic [DATA_W-1:0] mem_din,
    output logic              mem_doe,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n
);
    localparam int unsigned P       = CLK_PERIOD_PS;
    localparam int unsigned SET_CYC = max2(ns_to_cycles(T_AS_NS, P), ns_to_cycles(T_OES_NS, P));
    localparam int unsigned STB_CYC = max2(ns_to_cycles(T_WPL_NS, P), ns_to_cycles(T_DS_NS, P));
    localparam int unsigned HLD_CYC = max2(max2(ns_to_cycles(T_AH_NS, P), ns_to_cycles(T_DH_NS, P)),
                                           ns_to_cycles(T_OEH_NS, P));
    localparam int unsigned GAP_CYC = ns_to_cycles(T_WPH_NS, P);
    localparam int unsigned ACC_CYC = max2(ns_to_cycles(T_ACC_NS, P), ns_to_cycles(T_OE_NS, P));
    localparam int unsigned TMO_CYC = ns_to_cycles(POLL_TIMEOUT_NS, P);
    localparam int unsigned CNT_MAX = max2(max2(max2(SET_CYC, STB_CYC), max2(HLD_CYC, GAP_CYC)), ACC_CYC);
    localparam int unsigned TW      = bits_for(CNT_MAX);
    localparam int unsigned MW      = bits_for(TMO_CYC);

    logic          tmr_load, tmr_done;
    logic [TW-1:0] tmr_val;
    logic          tmo_clear, tmo_run, tmo_hit;

    eep_seq_fsm #(
        .ADDR_W (ADDR_W),  .DATA_W (DATA_W),  .TW (TW),
        .SET_CYC(SET_CYC), .STB_CYC(STB_CYC), .HLD_CYC(HLD_CYC),
        .GAP_CYC(GAP_CYC), .ACC_CYC(ACC_CYC)
    ) u_fsm (
        .clk      (clk),       .rst_n    (rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr (req_addr),  .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_error(rsp_error),
        .mem_addr (mem_addr),  .mem_dout (mem_dout),  .mem_din  (mem_din),
        .mem_doe  (mem_doe),   .mem_ce_n (mem_ce_n),  .mem_oe_n (mem_oe_n),
        .mem_we_n (mem_we_n),
        .tmr_load (tmr_load),  .tmr_val  (tmr_val),   .tmr_done (tmr_done),
        .tmo_clear(tmo_clear), .tmo_run  (tmo_run),   .tmo_hit  (tmo_hit)
    );

    eep_cycle_timer #(.TW(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
    );

    eep_poll_watch #(.LIMIT(TMO_CYC), .MW(MW)) u_watch (
        .clk(clk), .rst_n(rst_n), .clear(tmo_clear), .run(tmo_run), .expired(tmo_hit)
    );

    // Strobe-width run counters used only by the checks below.
    logic [TW:0] we_low_run, oe_low_run;

    // Count consecutive low cycles of the write and output enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_low_run <= '0;
            oe_low_run <= '0;
        end else begin
            we_low_run <= mem_we_n ? '0 : ((&we_low_run) ? we_low_run : we_low_run + 1'b1);
            oe_low_run <= mem_oe_n ? '0 : ((&oe_low_run) ? oe_low_run : oe_low_run + 1'b1);
        end
    end

    AST_WE_MIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (int'(we_low_run) >= STB_CYC));  // R2
    AST_OE_MIN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> (int'(oe_low_run) >= ACC_CYC));  // R5
    AST_STROBE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> ($past(!mem_ce_n) && mem_oe_n));  // R2
endmodule

// File: tb/tb_eep_host_seq.sv
// Self-checking bench: behavioural EEPROM with access-time and busy modelling,
// a vector table of reads and writes, then directed reset, busy and timeout tests.
module tb_eep_host_seq;
    localparam int SETUP = 2;    // ceil(10/5)
    localparam int PULSE = 20;   // ceil(100/5)
    localparam int HOLD  = 10;   // ceil(50/5)
    localparam int ACC   = 30;   // ceil(150/5)
    localparam int REC   = 10;   // ceil(50/5)
    localparam int TMO   = 4000; // 20000 ns / 5 ns
    localparam int NVEC  = 9;
    // {write, addr[8:0], wdata[7:0], expected rdata[7:0]}
    localparam logic [25:0] VEC [NVEC] = '{
        {1'b1, 9'h000, 8'h3C, 8'h3C},
        {1'b0, 9'h000, 8'h00, 8'h3C},
        {1'b1, 9'h1FF, 8'h80, 8'h80},
        {1'b0, 9'h1FF, 8'h00, 8'h80},
        {1'b0, 9'h055, 8'h00, 8'hF0},
        {1'b1, 9'h0AA, 8'h7F, 8'h7F},
        {1'b0, 9'h0AA, 8'h00, 8'h7F},
        {1'b1, 9'h100, 8'hFF, 8'hFF},
        {1'b0, 9'h001, 8'h00, 8'hA4}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [8:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic req_ready, rsp_valid, rsp_error, mem_doe, mem_ce_n, mem_oe_n, mem_we_n;
    logic [7:0] rsp_rdata, mem_dout, mem_din;
    logic [8:0] mem_addr;

    int checks = 0, errors = 0, cyc = 0;

    always #2.5 clk = ~clk;

    eep_host_seq #(.POLL_TIMEOUT_NS(20000)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_error(rsp_error),
        .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_din(mem_din),
        .mem_doe(mem_doe), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // ---------------- memory model ----------------
    logic [7:0] mem [512];
    int  busy_cnt = 0, busy_len = 300, acc_cnt = 0;
    logic stuck = 1'b0, last_b7 = 1'b0, m_prev_we = 1'b1;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 512; i++) mem[i] = 8'(i) ^ 8'hA5;
            busy_cnt  <= 0;
            m_prev_we <= 1'b1;
            acc_cnt   <= 0;
        end else begin
            m_prev_we <= mem_we_n;
            acc_cnt   <= (!mem_ce_n && !mem_oe_n) ? acc_cnt + 1 : 0;
            if (mem_we_n && !m_prev_we && !mem_ce_n) begin
                mem[mem_addr] <= mem_dout;
                last_b7       <= mem_dout[7];
                busy_cnt      <= busy_len;
            end else if (busy_cnt != 0) begin
                busy_cnt <= busy_cnt - 1;
            end
        end
    end

    always_comb begin
        if (!mem_ce_n && !mem_oe_n) begin
            if (acc_cnt < ACC - 1)               mem_din = 8'h5A;
            else if (stuck || busy_cnt != 0)     mem_din = {~last_b7, 7'h2A};
            else                                 mem_din = mem[mem_addr];
        end else begin
            mem_din = 8'h00;
        end
    end

    // ---------------- bus monitors ----------------
    logic p_we = 1'b1, p_oe = 1'b1, p_doe = 1'b0;
    logic [8:0] p_addr = '0, oe_addr = '0, wr_addr = '0;
    logic [7:0] p_dout = '0;
    int stable_cnt = 0, we_low = 0, hold_cnt = 0, oe_low = 0, oe_pulses = 0, we_rise_cyc = 0;
    int contention = 0;
    logic hold_on = 1'b0, pulse_bad = 1'b0, oe_bad = 1'b0, poll_bad = 1'b0, poll_phase = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (mem_addr != p_addr || mem_dout != p_dout || mem_doe != p_doe) stable_cnt = 0;
            else stable_cnt++;
            if (!mem_oe_n && (mem_doe || !mem_we_n)) contention++;
            // write strobe
            if (!mem_we_n && p_we) begin
                check(stable_cnt >= SETUP && mem_doe, "R3 setup before strobe", stable_cnt, SETUP);
                we_low = 0; pulse_bad = 1'b0;
            end
            if (!mem_we_n) begin
                we_low++;
                if (mem_ce_n || !mem_oe_n) pulse_bad = 1'b1;
                if (!p_we && (mem_addr != p_addr || mem_dout != p_dout)) pulse_bad = 1'b1;
            end
            if (mem_we_n && !p_we) begin
                check(we_low >= PULSE, "R2 strobe width", we_low, PULSE);
                check(!pulse_bad, "R2/R3 strobe levels", pulse_bad, 0);
                hold_on = 1'b1; hold_cnt = 1;
                poll_phase = 1'b1; wr_addr = mem_addr; we_rise_cyc = cyc; oe_pulses = 0;
            end else if (hold_on) begin
                if (!mem_ce_n && mem_doe && mem_addr == p_addr && mem_dout == p_dout) hold_cnt++;
                else begin
                    check(hold_cnt >= HOLD, "R4 hold after strobe", hold_cnt, HOLD);
                    hold_on = 1'b0;
                end
            end
            // read windows
            if (!mem_oe_n && p_oe) begin
                oe_low = 0; oe_addr = mem_addr; oe_bad = 1'b0; poll_bad = 1'b0;
            end
            if (!mem_oe_n) begin
                oe_low++;
                if (mem_addr != oe_addr || mem_ce_n) oe_bad = 1'b1;
                if (poll_phase && mem_addr != wr_addr) poll_bad = 1'b1;
            end
            if (mem_oe_n && !p_oe) begin
                check(oe_low >= ACC && !oe_bad, "R5 access window", oe_low, ACC);
                if (poll_phase) check(!poll_bad, "R6 poll address", oe_addr, wr_addr);
                oe_pulses++;
            end
            if (rsp_valid) poll_phase = 1'b0;
        end
        p_we = mem_we_n; p_oe = mem_oe_n; p_doe = mem_doe; p_addr = mem_addr; p_dout = mem_dout;
    end

    // ---------------- watchdog ----------------
    always @(negedge clk) begin
        if (cyc > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- request helpers ----------------
    task automatic issue(input logic wr, input logic [8:0] a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_rsp(output logic [7:0] rd, output logic er, output int at);
        while (!rsp_valid) @(negedge clk);
        rd = rsp_rdata; er = rsp_error; at = cyc;
        @(negedge clk);
    endtask

    logic [7:0] rd;
    logic er;
    int at, not_ready_bad;

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(mem_ce_n && mem_oe_n && mem_we_n && !mem_doe, "R1 strobes in reset",
              {mem_ce_n, mem_oe_n, mem_we_n, mem_doe}, 4'b1110);
        check(req_ready && !rsp_valid, "R1 handshake in reset", {req_ready, rsp_valid}, 2'b10);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_ce_n && mem_oe_n && mem_we_n && !mem_doe && req_ready && !rsp_valid,
              "R1 after reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_doe, req_ready, rsp_valid}, 6'b111010);

        // Vector table: R5 reads, R6 writes with slow and fast completion
        for (int i = 0; i < NVEC; i++) begin
            busy_len = (i % 2 == 0) ? 300 : 7;
            issue(VEC[i][25], VEC[i][24:16], VEC[i][15:8]);
            wait_rsp(rd, er, at);
            check(rd == VEC[i][7:0], VEC[i][25] ? "R6 write poll data" : "R5 read data", rd, VEC[i][7:0]);
            check(!er, "R7 no error on normal completion", er, 0);
            if (VEC[i][25]) begin
                check(at - we_rise_cyc > busy_len, "R6 done not before busy end", at - we_rise_cyc, busy_len);
                if (busy_len > 100) check(oe_pulses >= 2, "R6 repeated polls", oe_pulses, 2);
                else                check(oe_pulses == 1, "R6 single poll", oe_pulses, 1);
            end
        end

        // R8: request held while a write is busy is neither accepted nor performed
        busy_len = 300;
        issue(1'b1, 9'h044, 8'h12);
        not_ready_bad = 0;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 9'h033; req_wdata = 8'h00;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (req_ready) not_ready_bad++;
        end
        req_valid = 1'b0;
        check(not_ready_bad == 0, "R8 ready low while busy", not_ready_bad, 0);
        wait_rsp(rd, er, at);
        check(rd == 8'h12 && !er, "R8 busy write completes", rd, 8'h12);
        issue(1'b0, 9'h033, 8'h00);
        wait_rsp(rd, er, at);
        check(rd == 8'h96, "R8 stray write had no effect", rd, 8'h96);

        // R7: memory never finishes, polling gives up
        stuck = 1'b1;
        issue(1'b1, 9'h010, 8'h55);
        wait_rsp(rd, er, at);
        check(er == 1'b1, "R7 timeout flag", er, 1);
        check(at - we_rise_cyc >= TMO && at - we_rise_cyc <= TMO + 2 * (ACC + REC),
              "R7 timeout instant", at - we_rise_cyc, TMO);
        stuck = 1'b0;
        check(req_ready, "R7 idle after timeout", req_ready, 1);
        issue(1'b0, 9'h010, 8'h00);
        wait_rsp(rd, er, at);
        check(rd == 8'h55 && !er, "R7 next request after timeout", rd, 8'h55);

        // R9: no bus contention over the whole run
        check(contention == 0, "R9 no drive or strobe under OE", contention, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule